// File: doc/BRIEF.md
# Voice Trigger Mode Controller

This block sits between four active-high push-button or sensor inputs and a voice playback engine. It filters each input against contact bounce at sample-rate ticks. It decides which input owns the engine and sends the engine three kinds of command: start a sentence (from its first word, or from its repeating second part), restart it, and stop it at once. The engine reports back a busy level, a pulse at the end of every word, and a pulse at the end of the last word of a sentence.

Each input has its own set of mode bits:
- edge or level triggering
- hold (release cuts playback short) or unhold (release has no effect)
- retrigger or irretrigger while playing
- fast or slow debounce
- looping of the second part of a two-part sentence
- play on/off toggling
- a dynamic mode in which a global gate input switches the input between fast debounce with irretrigger and slow debounce with retrigger

One global bit selects whether a newly accepted input preempts the sentence that is playing (last-key priority) or is ignored until it ends (first-key priority). Inputs are indexed 0 to 3, and a higher index wins a tie.

Top module: `voice_trigger_ctrl`

## Requirements
- R1: With fast debounce, an input change is accepted at the first sample tick after it reaches the input synchronizer (FAST_TICKS = 1), so an idle input starts playback within 12 clock cycles of going high when ticks arrive every 4 cycles.
- R2: With slow debounce, an input change is accepted only after it has been stable for SLOW_TICKS (96) consecutive ticks; a pulse shorter than that starts nothing.
- R3: In edge mode, one press starts the sentence exactly once, whether the press is shorter or longer than the sentence.
- R4: In level mode, the sentence restarts from its first word each time it ends while the input is held; after release, a stop is issued at the next end of word, and not before.
- R5: In hold mode, releasing the owning input issues an immediate stop; in unhold mode, release lets the sentence run to its end with no stop command.
- R6: With retrigger, a new press of the owning input while playing issues a start of part 0 (first word) again.
- R7: With irretrigger, presses of the owning input while playing issue no command.
- R8: With looping, each end of sentence is followed by a start of part 1 (cmd_part = 1), indefinitely in unhold mode; in hold mode, release stops the loop at once.
- R9: For an input with its dynamic bit set, the gate input is treated as high while the engine is idle. While the engine is busy and the gate is low, the input uses slow debounce and retrigger. While busy with the gate high, it keeps its configured fast debounce and irretrigger.
- R10: Among inputs accepted in the same cycle, the one with the highest index wins (3 > 2 > 1 > 0), and cmd_key carries that index.
- R11: With last_key_mode = 1, an accepted press of a different input while playing starts that input's sentence; with last_key_mode = 0, such a press is ignored.
- R12: With play on/off set, a press of the owning input while playing issues a stop; a press while idle starts playback.
- R13: After reset, all inputs count as released, no command is issued until an input is accepted, and cmd_start and cmd_stop are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample-rate strobe that paces debounce |
| trig_in | input | NUM_KEYS | Raw active-high trigger inputs, index 3 has top priority |
| cfg_level | input | NUM_KEYS | 1 = level mode, 0 = edge mode |
| cfg_hold | input | NUM_KEYS | 1 = release stops playback at once |
| cfg_retrig | input | NUM_KEYS | 1 = owning input may restart while playing |
| cfg_slow | input | NUM_KEYS | 1 = slow debounce, 0 = fast |
| cfg_loop | input | NUM_KEYS | 1 = second part of the sentence repeats |
| cfg_toggle | input | NUM_KEYS | 1 = play on/off behaviour |
| cfg_dyn | input | NUM_KEYS | 1 = debounce and retrigger follow the gate input while busy |
| frsb_in | input | 1 | Gate for the dynamic mode, low forces slow debounce and retrigger |
| last_key_mode | input | 1 | 1 = last-key priority, 0 = first-key priority |
| eng_busy | input | 1 | Engine is playing |
| eng_word_end | input | 1 | Pulse at the end of each word |
| eng_sent_end | input | 1 | Pulse at the end of the last word of a sentence |
| cmd_start | output | 1 | Pulse: start or restart a sentence |
| cmd_stop | output | 1 | Pulse: stop playback at once |
| cmd_key | output | KW | Input whose sentence is started |
| cmd_part | output | 1 | 0 = from first word, 1 = from repeating second part |

## Verification
The bench goes after timing edges where a slip changes what is heard. These are a slow-debounce pulse just short of the full count, a level release partway through a word, a retrigger arriving mid-sentence, and a dynamic input whose release is still being slow-filtered when the next press comes. A debouncer that counts one tick short would let a glitch start playback. A level mode that stops on release instead of at the end of the word would cut a word in half. Swapped priority would answer the wrong input on a simultaneous press. A first-key setting that still preempts, or a toggle that restarts instead of stopping, shows up as an extra start in the engine model's count.

// File: rtl/vtc_pkg.sv
// Shared types for the voice trigger mode controller.
package vtc_pkg;

    // Outcome of trigger arbitration in one cycle.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_START = 2'd1,
        ACT_STOP  = 2'd2
    } vtc_act_e;

endpackage

// File: rtl/vtc_debounce.sv
// Debounces one trigger input.
// Assumes: tick is a one-cycle strobe; raw is asynchronous and is first
// brought through two flops. A change is accepted after it has been seen
// on LIMIT consecutive ticks, where LIMIT is picked by 'slow' each tick.
module vtc_debounce #(
    parameter int SLOW_TICKS = 96,
    parameter int FAST_TICKS = 1,
    localparam int CW = $clog2(SLOW_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic slow,
    output logic level,
    output logic rise,
    output logic fall
);
    logic          sync1, sync2;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Pick the stability count for this input.
    assign lim = slow ? CW'(SLOW_TICKS) : CW'(FAST_TICKS);

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Count ticks of disagreement and accept the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt   <= '0;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (tick) begin
                if (sync2 == level) begin
                    cnt <= '0;
                end else if (cnt + CW'(1) >= lim) begin
                    level <= sync2;
                    cnt   <= '0;
                    rise  <= sync2;
                    fall  <= !sync2;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R2: the count never exceeds the slow limit.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(SLOW_TICKS));

    // R1: the accepted level moves only on a sample tick.
    a_r1_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> $past(tick));

    // R13: an edge pulse always matches the new level.
    a_r13_edge_match: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> level);
endmodule

// File: rtl/vtc_arbiter.sv
// Chooses which newly accepted trigger, if any, acts this cycle.
// Assumes: rise is a one-cycle pulse per input; config vectors are the
// effective ones (dynamic override already applied). Higher index wins.
module vtc_arbiter
    import vtc_pkg::*;
#(
    parameter int NUM_KEYS = 4,
    localparam int KW = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] rise,
    input  logic                active,
    input  logic [KW-1:0]       owner,
    input  logic [NUM_KEYS-1:0] eff_retrig,
    input  logic [NUM_KEYS-1:0] cfg_toggle,
    input  logic                last_key_mode,
    output vtc_act_e            acc_act,
    output logic [KW-1:0]       acc_key
);
    logic [NUM_KEYS-1:0] elig;
    logic                found;

    // Mark which pressed inputs may act given ownership and modes.
    always_comb begin
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (!active)
                elig[k] = rise[k];
            else if (KW'(k) == owner)
                elig[k] = rise[k] && (cfg_toggle[k] || eff_retrig[k]);
            else
                elig[k] = rise[k] && last_key_mode;
        end
    end

    // Priority pick: the highest eligible index overrides lower ones.
    always_comb begin
        found   = 1'b0;
        acc_key = '0;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (elig[k]) begin
                found   = 1'b1;
                acc_key = KW'(k);
            end
        end
    end

    // Turn the pick into an action; the owner with toggling stops.
    always_comb begin
        if (!found)
            acc_act = ACT_NONE;
        else if (active && acc_key == owner && cfg_toggle[acc_key])
            acc_act = ACT_STOP;
        else
            acc_act = ACT_START;
    end

    // R10: no pressed input above the winner was eligible.
    a_r10_top_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_act != ACT_NONE) |-> (((rise >> acc_key) >> 1) & (elig >> acc_key) >> 1) == '0);

    // R11: with first-key priority, only the owner acts while playing.
    a_r11_first_key: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last_key_mode && acc_act != ACT_NONE) |-> acc_key == owner);

    // R7: an owner without retrigger or toggle never acts.
    a_r7_irretrig: assert property (@(posedge clk) disable iff (!rst_n)
        (active && acc_act != ACT_NONE && acc_key == owner) |->
            (eff_retrig[owner] || cfg_toggle[owner]));
endmodule

// File: rtl/vtc_sequencer.sv
// Owns the engine: issues start, restart and stop commands from the
// arbitration result, the owner's release and the engine's word pulses.
// Assumes: eng_sent_end coincides with the last eng_word_end; a start
// while the engine is busy restarts it.
module vtc_sequencer
    import vtc_pkg::*;
#(
    parameter int NUM_KEYS = 4,
    localparam int KW = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  vtc_act_e            acc_act,
    input  logic [KW-1:0]       acc_key,
    input  logic [NUM_KEYS-1:0] key_level,
    input  logic [NUM_KEYS-1:0] key_fall,
    input  logic [NUM_KEYS-1:0] cfg_level,
    input  logic [NUM_KEYS-1:0] cfg_hold,
    input  logic [NUM_KEYS-1:0] cfg_loop,
    input  logic                eng_word_end,
    input  logic                eng_sent_end,
    output logic                active,
    output logic [KW-1:0]       owner,
    output logic                cmd_start,
    output logic                cmd_stop,
    output logic [KW-1:0]       cmd_key,
    output logic                cmd_part
);
    logic stop_pend;
    logic pend_n;
    logic own_fall, own_held, own_level, own_hold, own_loop;

    // Owner's status and modes.
    assign own_fall  = key_fall[owner];
    assign own_held  = key_level[owner];
    assign own_level = cfg_level[owner];
    assign own_hold  = cfg_hold[owner];
    assign own_loop  = cfg_loop[owner];
    assign pend_n    = stop_pend || (own_fall && own_level);

    // Command and ownership state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            owner     <= '0;
            stop_pend <= 1'b0;
            cmd_start <= 1'b0;
            cmd_stop  <= 1'b0;
            cmd_key   <= '0;
            cmd_part  <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            cmd_stop  <= 1'b0;
            if (acc_act == ACT_STOP) begin
                cmd_stop  <= 1'b1;
                active    <= 1'b0;
                stop_pend <= 1'b0;
            end else if (acc_act == ACT_START) begin
                cmd_start <= 1'b1;
                cmd_key   <= acc_key;
                cmd_part  <= 1'b0;
                active    <= 1'b1;
                owner     <= acc_key;
                stop_pend <= 1'b0;
            end else if (active) begin
                if (own_fall && own_hold) begin
                    cmd_stop  <= 1'b1;
                    active    <= 1'b0;
                    stop_pend <= 1'b0;
                end else if (eng_word_end && pend_n) begin
                    cmd_stop  <= 1'b1;
                    active    <= 1'b0;
                    stop_pend <= 1'b0;
                end else if (eng_sent_end) begin
                    if ((own_level && own_held) || own_loop) begin
                        cmd_start <= 1'b1;
                        cmd_key   <= owner;
                        cmd_part  <= own_loop;
                    end else begin
                        active <= 1'b0;
                    end
                end else begin
                    stop_pend <= pend_n;
                end
            end
        end
    end

    // R13: start and stop are exclusive.
    a_r13_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_start && cmd_stop));

    // R13: a stop is only sent for playback that was owned.
    a_r13_stop_owned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |-> $past(active));

    // R4: a pending stop belongs to an owned sentence.
    a_r4_pend_owned: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pend |-> active);

    // R8: a part-1 start repeats the current owner's sentence.
    a_r8_loop_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_part) |-> ($past(active) && cmd_key == $past(owner)));

    // R5: a held-mode release with no competing press stops next cycle.
    a_r5_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (active && own_fall && own_hold && acc_act == ACT_NONE) |=> cmd_stop);
endmodule

// File: rtl/voice_trigger_ctrl.sv
// Top: per-input debounce, dynamic mode override, arbitration and
// command sequencing for a voice playback engine.
// Assumes: smp_tick is a single-cycle strobe at the sample rate.
module voice_trigger_ctrl
    import vtc_pkg::*;
#(
    parameter int NUM_KEYS   = 4,
    parameter int SLOW_TICKS = 96,
    parameter int FAST_TICKS = 1,
    localparam int KW = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_tick,
    input  logic [NUM_KEYS-1:0] trig_in,
    input  logic [NUM_KEYS-1:0] cfg_level,
    input  logic [NUM_KEYS-1:0] cfg_hold,
    input  logic [NUM_KEYS-1:0] cfg_retrig,
    input  logic [NUM_KEYS-1:0] cfg_slow,
    input  logic [NUM_KEYS-1:0] cfg_loop,
    input  logic [NUM_KEYS-1:0] cfg_toggle,
    input  logic [NUM_KEYS-1:0] cfg_dyn,
    input  logic                frsb_in,
    input  logic                last_key_mode,
    input  logic                eng_busy,
    input  logic                eng_word_end,
    input  logic                eng_sent_end,
    output logic                cmd_start,
    output logic                cmd_stop,
    output logic [KW-1:0]       cmd_key,
    output logic                cmd_part
);
    logic [NUM_KEYS-1:0] key_level, key_rise, key_fall;
    logic [NUM_KEYS-1:0] eff_slow, eff_retrig;
    logic                force_mode;
    logic                active;
    logic [KW-1:0]       owner;
    vtc_act_e            acc_act;
    logic [KW-1:0]       acc_key;

    // Gate counts as high while idle; low while busy forces the override.
    assign force_mode = eng_busy && !frsb_in;
    assign eff_slow   = cfg_slow   | (cfg_dyn & {NUM_KEYS{force_mode}});
    assign eff_retrig = cfg_retrig | (cfg_dyn & {NUM_KEYS{force_mode}});

    // One debouncer per trigger input.
    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_deb
        vtc_debounce #(
            .SLOW_TICKS(SLOW_TICKS),
            .FAST_TICKS(FAST_TICKS)
        ) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (smp_tick),
            .raw  (trig_in[g]),
            .slow (eff_slow[g]),
            .level(key_level[g]),
            .rise (key_rise[g]),
            .fall (key_fall[g])
        );
    end

    vtc_arbiter #(.NUM_KEYS(NUM_KEYS)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise         (key_rise),
        .active       (active),
        .owner        (owner),
        .eff_retrig   (eff_retrig),
        .cfg_toggle   (cfg_toggle),
        .last_key_mode(last_key_mode),
        .acc_act      (acc_act),
        .acc_key      (acc_key)
    );

    vtc_sequencer #(.NUM_KEYS(NUM_KEYS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_act     (acc_act),
        .acc_key     (acc_key),
        .key_level   (key_level),
        .key_fall    (key_fall),
        .cfg_level   (cfg_level),
        .cfg_hold    (cfg_hold),
        .cfg_loop    (cfg_loop),
        .eng_word_end(eng_word_end),
        .eng_sent_end(eng_sent_end),
        .active      (active),
        .owner       (owner),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .cmd_key     (cmd_key),
        .cmd_part    (cmd_part)
    );

    // R9: the override never applies while the engine is idle.
    a_r9_idle_plain: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (eff_slow == cfg_slow && eff_retrig == cfg_retrig));
endmodule

// File: tb/voice_trigger_ctrl_test.sv
// Directed bench with a behavioural playback engine: 4-word sentences,
// part 1 starts at word 2. Sample tick every 4 clocks.
module voice_trigger_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick;
    logic [3:0] trig, c_lvl, c_hold, c_rt, c_slow, c_loop, c_tog, c_dyn;
    logic       frsb, lkm;
    logic       eng_busy, eng_word_end, eng_sent_end;
    logic       cmd_start, cmd_stop, cmd_part;
    logic [1:0] cmd_key;
    int         word_len = 40;
    int         n_checks = 0, n_fail = 0;
    int         n_start, n_stop, wc;
    logic [1:0] last_key, wi;
    logic       last_part;
    logic [1:0] div;

    always #5 clk = ~clk;

    voice_trigger_ctrl uut (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .trig_in(trig),
        .cfg_level(c_lvl), .cfg_hold(c_hold), .cfg_retrig(c_rt),
        .cfg_slow(c_slow), .cfg_loop(c_loop), .cfg_toggle(c_tog),
        .cfg_dyn(c_dyn), .frsb_in(frsb), .last_key_mode(lkm),
        .eng_busy(eng_busy), .eng_word_end(eng_word_end),
        .eng_sent_end(eng_sent_end), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_key(cmd_key), .cmd_part(cmd_part)
    );

    // Sample tick generator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin div <= '0; smp_tick <= 1'b0; end
        else begin div <= div + 2'd1; smp_tick <= (div == 2'd3); end
    end

    // Engine model.
    always_ff @(posedge clk) begin
        eng_word_end <= 1'b0;
        eng_sent_end <= 1'b0;
        if (!rst_n) begin
            eng_busy <= 1'b0; wc <= 0; wi <= '0;
        end else if (cmd_stop) begin
            eng_busy <= 1'b0;
        end else if (cmd_start) begin
            eng_busy <= 1'b1; wc <= 0; wi <= cmd_part ? 2'd2 : 2'd0;
        end else if (eng_busy) begin
            if (wc == word_len - 1) begin
                wc <= 0;
                eng_word_end <= 1'b1;
                if (wi == 2'd3) begin eng_busy <= 1'b0; eng_sent_end <= 1'b1; end
                else wi <= wi + 2'd1;
            end else wc <= wc + 1;
        end
    end

    // Command log.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_start <= 0; n_stop <= 0; last_key <= '0; last_part <= 1'b0;
        end else begin
            if (cmd_start) begin
                n_start <= n_start + 1; last_key <= cmd_key; last_part <= cmd_part;
            end
            if (cmd_stop) n_stop <= n_stop + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int k, input int n);
        trig[k] = 1'b1; idle(n); trig[k] = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trig = '0; c_lvl = '0; c_hold = '0; c_rt = '0;
        c_slow = '0; c_loop = '0; c_tog = '0; c_dyn = '0;
        frsb = 1'b1; lkm = 1'b0; word_len = 40;
        idle(4); rst_n = 1'b1; idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R13 start low", int'(cmd_start), 0);
        idle(50);
        chk("R13 no command", n_start + n_stop, 0);
    endtask

    task automatic t_debounce();
        int got = 0;
        do_reset();
        trig[1] = 1'b1;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (cmd_start) got = 1; end
        trig[1] = 1'b0;
        chk("R1 fast accept", got, 1);
        do_reset(); c_slow[1] = 1'b1;
        press(1, 200); idle(50);
        chk("R2 short pulse ignored", n_start, 0);
        trig[1] = 1'b1; idle(360);
        chk("R2 not early", n_start, 0);
        idle(140); trig[1] = 1'b0; idle(5);
        chk("R2 full count", n_start, 1);
    endtask

    task automatic t_edge();
        do_reset();
        press(1, 20); idle(80);
        chk("R5 unhold runs on", int'(eng_busy), 1);
        idle(200);
        chk("R3 short press once", n_start, 1);
        chk("R5 unhold no stop", n_stop, 0);
        do_reset();
        press(1, 400); idle(100);
        chk("R3 long press once", n_start, 1);
    endtask

    task automatic t_level();
        do_reset(); c_lvl[2] = 1'b1;
        trig[2] = 1'b1; idle(400);
        chk("R4 busy at release", int'(eng_busy), 1);
        trig[2] = 1'b0; idle(5);
        chk("R4 no early stop", n_stop, 0);
        idle(200);
        chk("R4 repeats while held", n_start, 3);
        chk("R4 stop at word end", n_stop, 1);
        chk("R4 idle after", int'(eng_busy), 0);
    endtask

    task automatic t_hold();
        do_reset(); c_hold[1] = 1'b1;
        press(1, 60); idle(30);
        chk("R5 hold stop", n_stop, 1);
        chk("R5 hold idle", int'(eng_busy), 0);
    endtask

    task automatic t_retrig();
        do_reset(); c_rt[1] = 1'b1;
        press(1, 20); idle(80); press(1, 20); idle(80);
        chk("R6 restart count", n_start, 2);
        chk("R6 from first word", int'(last_part), 0);
        chk("R6 still busy", int'(eng_busy), 1);
        do_reset();
        press(1, 20); idle(80); press(1, 20); idle(80);
        chk("R7 ignored", n_start, 1);
        chk("R7 ended on time", int'(eng_busy), 0);
    endtask

    task automatic t_loop();
        do_reset(); c_loop[3] = 1'b1;
        press(3, 20); idle(700);
        chk("R8 repeats", int'(n_start >= 4), 1);
        chk("R8 part one", int'(last_part), 1);
        chk("R8 unhold endless", int'(eng_busy), 1);
        do_reset(); c_loop[3] = 1'b1; c_hold[3] = 1'b1;
        press(3, 300); idle(30);
        chk("R8 hold loop stop", n_stop, 1);
        chk("R8 hold loop part", int'(last_part), 1);
    endtask

    task automatic t_frsb();
        do_reset(); c_dyn[2] = 1'b1; frsb = 1'b0; word_len = 400;
        press(2, 8); idle(20);
        chk("R9 idle fast", n_start, 1);
        idle(450);
        press(2, 100); idle(100);
        chk("R9 glitch filtered", n_start, 1);
        press(2, 450); idle(10);
        chk("R9 forced retrigger", n_start, 2);
        do_reset(); c_dyn[2] = 1'b1; frsb = 1'b1; word_len = 400;
        press(2, 20); idle(100); press(2, 450); idle(10);
        chk("R9 gate high irretrig", n_start, 1);
    endtask

    task automatic t_prio();
        do_reset();
        trig = 4'b1101; idle(20); trig = '0; idle(5);
        chk("R10 one start", n_start, 1);
        chk("R10 top index", int'(last_key), 3);
        do_reset();
        trig = 4'b0011; idle(20); trig = '0; idle(5);
        chk("R10 pair", int'(last_key), 1);
    endtask

    task automatic t_lastkey();
        do_reset(); lkm = 1'b1;
        press(1, 20); idle(40); press(2, 20); idle(5);
        chk("R11 preempt count", n_start, 2);
        chk("R11 preempt key", int'(last_key), 2);
        do_reset();
        press(1, 20); idle(40); press(2, 20); idle(5);
        chk("R11 first key kept", n_start, 1);
        chk("R11 first key id", int'(last_key), 1);
    endtask

    task automatic t_toggle();
        do_reset(); c_tog[0] = 1'b1;
        press(0, 20); idle(60); press(0, 20); idle(10);
        chk("R12 second press stops", n_stop, 1);
        chk("R12 idle", int'(eng_busy), 0);
        press(0, 20); idle(5);
        chk("R12 play again", n_start, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_debounce();
        t_edge();
        t_level();
        t_hold();
        t_retrig();
        t_loop();
        t_frsb();
        t_prio();
        t_lastkey();
        t_toggle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule